// File: doc/BRIEF.md
# Phase Step Sequencer

This block turns one request to move the phase of a clock-generator counter into a train of single step pulses. The request names the counter, the number of eighth-period steps and the direction. The target can be any of the output counters or the feedback counter. The block takes the request through a valid/ready handshake. It issues one step pulse and waits for that counter to acknowledge it. It then leaves a fixed quiet gap before the next step. After the last acknowledge it raises a one-cycle done pulse and returns to idle.

Each step moves the selected counter by one eighth of the oscillator period, either forward or back. A counter's position therefore wraps modulo eight steps. The counters and the oscillator sit outside the block. A request with an unknown target code or a zero step count is taken and discarded, and an error pulse is raised for it.

Top module: `phase_step_seq`

## Requirements
- R1: After reset, req_ready is 1 and busy, done, err and every step_strobe bit are 0.
- R2: req_target codes 0 to 8 select output counters 0 to 8 on step_strobe bits 0 to 8. Code 9 selects the feedback counter on step_strobe bit 9. At most one strobe bit is high in any cycle, and no other counter receives a step.
- R3: An accepted legal request with req_steps between 1 and 7 produces exactly that many step pulses, each one cycle wide.
- R4: step_up is 1 for a forward request and 0 for a backward one, and it holds for the whole request. A forward request of N steps moves the target's position by +N eighths modulo 8, and a backward request moves it by -N eighths modulo 8.
- R5: A request is taken at a clock edge where req_valid and req_ready are both 1. req_ready is 1 only while idle, so a request presented while a sequence runs is not taken.
- R6: busy is 1 from the cycle after acceptance through the done cycle, and 0 otherwise.
- R7: The first step pulse comes in the cycle right after acceptance. Each later pulse waits for step_ack. It appears in the third cycle after the cycle in which the acknowledge was taken, which leaves two empty cycles.
- R8: done is a one-cycle pulse in the cycle after the final acknowledge was taken. req_ready is 1 in the following cycle.
- R9: A taken request with req_target of 10 to 15 or req_steps of 0 raises err for exactly the next cycle. It emits no step, and the block stays idle.
- R10: step_ack has no effect unless the block is waiting for an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_target | input | 4 | Counter code: 0-8 output counters, 9 feedback counter |
| req_steps | input | 3 | Number of eighth-period steps, 1 to 7 |
| req_up | input | 1 | 1 forward, 0 backward |
| step_strobe | output | 10 | One-hot step pulse to the selected counter |
| step_up | output | 1 | Direction that goes with step_strobe |
| step_ack | input | 1 | Counter has applied the current step |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after the final step is acknowledged |
| err | output | 1 | One-cycle pulse after an illegal request |

## Verification
The bench sweeps every legal target, every step count and both directions, and varies the acknowledge latency. It models each counter as a position modulo eight. A sequencer that miscounted the remaining steps would leave a counter off by one eighth. A sequencer that stepped a neighbouring counter would move a position that should be untouched. A sequencer that ignored the gap would put strobes closer than three cycles after an acknowledge. The bench also sends the six unused target codes and a zero count, and expects an error with no step. A request held on the bus during a run must not be taken. A stray acknowledge while idle must not shorten the next request.

// File: rtl/pss_pkg.sv
`timescale 1ns/1ps
package pss_pkg;

    localparam int unsigned TGT_W       = 4;
    localparam int unsigned CNT_W       = 3;
    localparam int unsigned DEF_NUM_OUT = 9;
    localparam int unsigned DEF_MIN_GAP = 2;

    typedef struct packed {
        logic [TGT_W-1:0] tgt;
        logic [CNT_W-1:0] steps;
        logic             up;
    } shift_req_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ISSUE = 3'd1,
        ST_WAIT  = 3'd2,
        ST_GAP   = 3'd3,
        ST_FIN   = 3'd4
    } seq_state_e;

    // legal when the code names an existing counter and at least one step is asked
    function automatic logic req_legal(input shift_req_t r, input int unsigned n_cnt);
        return (32'(r.tgt) < n_cnt) && (r.steps != '0);
    endfunction

endpackage

// File: rtl/pss_req_check.sv
`timescale 1ns/1ps
module pss_req_check
    import pss_pkg::*;
#(
    parameter int unsigned NUM_CNT = 10
) (
    input  shift_req_t         req,
    output logic               legal,
    output logic [NUM_CNT-1:0] sel
);

    assign legal = req_legal(req, NUM_CNT);

    generate
        for (genvar i = 0; i < NUM_CNT; i++) begin : g_dec
            assign sel[i] = (req.tgt == TGT_W'(i));
        end
    endgenerate

    // R2: a legal code decodes to exactly one counter
    always_comb begin
        if (legal === 1'b1) begin
            a_legal_onehot_r2: assert ($onehot(sel));
        end
    end

endmodule

// File: rtl/pss_gap_timer.sv
`timescale 1ns/1ps
module pss_gap_timer #(
    parameter int unsigned GAP = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic last
);

    localparam int unsigned W = (GAP < 1) ? 1 : $clog2(GAP + 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= W'(GAP);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign last = (cnt_q == W'(1));

    // R7: a new gap is only started once the previous one has run out
    p_reload_clear_r7: assert property (@(posedge clk) disable iff (rst)
        load |-> (cnt_q == '0));

endmodule

// File: rtl/pss_seq_fsm.sv
`timescale 1ns/1ps
module pss_seq_fsm
    import pss_pkg::*;
#(
    parameter int unsigned NUM_CNT = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  shift_req_t         req,
    input  logic               legal,
    input  logic [NUM_CNT-1:0] sel,
    input  logic               step_ack,
    input  logic               gap_last,
    output logic               gap_load,
    output logic               ready,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [NUM_CNT-1:0] strobe,
    output logic               step_up
);

    seq_state_e         state_q, state_d;
    logic [CNT_W-1:0]   rem_q;
    logic [NUM_CNT-1:0] sel_q;
    logic               up_q;
    logic               err_q;
    logic               take;
    logic               ack_take;
    logic               final_ack;

    assign take      = req_valid && (state_q == ST_IDLE);
    assign ack_take  = (state_q == ST_WAIT) && step_ack;
    assign final_ack = ack_take && (rem_q == CNT_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take && legal) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (ack_take) state_d = final_ack ? ST_FIN : ST_GAP;
            ST_GAP:   if (gap_last) state_d = ST_ISSUE;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
            sel_q   <= '0;
            up_q    <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= take && !legal;
            if (take && legal) begin
                rem_q <= req.steps;
                sel_q <= sel;
                up_q  <= req.up;
            end else if (ack_take) begin
                rem_q <= rem_q - CNT_W'(1);
            end
        end
    end

    assign gap_load = ack_take && !final_ack;
    assign ready    = (state_q == ST_IDLE);
    assign busy     = (state_q != ST_IDLE);
    assign done     = (state_q == ST_FIN);
    assign err      = err_q;
    assign strobe   = (state_q == ST_ISSUE) ? sel_q : '0;
    assign step_up  = up_q;

    // R2: never more than one counter stepped at once
    p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe));

    // R3: while a sequence runs there is always a step left to deliver
    p_steps_left_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |-> (rem_q != '0));

    // R4: direction does not change inside a sequence
    p_dir_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(step_up));

    // R8: done lasts one cycle and is followed by idle
    p_done_once_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && ready));

    // R10: an acknowledge while idle leaves the block idle
    p_idle_ack_r10: assert property (@(posedge clk) disable iff (rst)
        (ready && step_ack && !req_valid) |=> ready);

endmodule

// File: rtl/phase_step_seq.sv
`timescale 1ns/1ps
module phase_step_seq
    import pss_pkg::*;
#(
    parameter int unsigned NUM_OUT = DEF_NUM_OUT,
    parameter int unsigned MIN_GAP = DEF_MIN_GAP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [TGT_W-1:0] req_target,
    input  logic [CNT_W-1:0] req_steps,
    input  logic             req_up,
    output logic [NUM_OUT:0] step_strobe,
    output logic             step_up,
    input  logic             step_ack,
    output logic             busy,
    output logic             done,
    output logic             err
);

    localparam int unsigned NUM_CNT = NUM_OUT + 1;

    shift_req_t         req;
    logic               legal;
    logic [NUM_CNT-1:0] sel;
    logic               gap_load;
    logic               gap_last;

    assign req = '{tgt: req_target, steps: req_steps, up: req_up};

    pss_req_check #(.NUM_CNT(NUM_CNT)) u_check (
        .req   (req),
        .legal (legal),
        .sel   (sel)
    );

    pss_gap_timer #(.GAP(MIN_GAP)) u_gap (
        .clk  (clk),
        .rst  (rst),
        .load (gap_load),
        .last (gap_last)
    );

    pss_seq_fsm #(.NUM_CNT(NUM_CNT)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req       (req),
        .legal     (legal),
        .sel       (sel),
        .step_ack  (step_ack),
        .gap_last  (gap_last),
        .gap_load  (gap_load),
        .ready     (req_ready),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .strobe    (step_strobe),
        .step_up   (step_up)
    );

    // R5: the block never offers to take a request while stepping
    p_no_take_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (|step_strobe) |-> !req_ready);

    // R7: a legal request starts stepping in the next cycle
    p_first_step_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && legal) |=> ((|step_strobe) && busy));

    // R7: after a step at least three cycles pass before the next one
    p_step_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (|step_strobe) |=> !(|step_strobe) ##1 !(|step_strobe) ##1 !(|step_strobe));

    // R9: an illegal request is flagged and dropped
    p_bad_req_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !legal) |=> (err && req_ready && !(|step_strobe)));

    // R6: busy and ready are never both high
    p_busy_ready_r6: assert property (@(posedge clk) disable iff (rst)
        !(busy && req_ready));

endmodule

// File: tb/phase_step_seq_bench.sv
`timescale 1ns/1ps
module phase_step_seq_bench;

    localparam int NC      = 10;
    localparam int MIN_GAP = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [3:0]    req_target = '0;
    logic [2:0]    req_steps = '0;
    logic          req_up = 1'b0;
    logic [NC-1:0] step_strobe;
    logic          step_up;
    logic          model_ack = 1'b0;
    logic          spur_ack = 1'b0;
    logic          step_ack;
    logic          busy, done, err;

    assign step_ack = model_ack | spur_ack;

    always #2.5 clk = ~clk;

    phase_step_seq u_phase_step_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_target  (req_target),
        .req_steps   (req_steps),
        .req_up      (req_up),
        .step_strobe (step_strobe),
        .step_up     (step_up),
        .step_ack    (step_ack),
        .busy        (busy),
        .done        (done),
        .err         (err)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    int pos [NC];
    int exp_pos [NC];
    int n_strobe, first_cyc, last_ack_cyc, gap_seen;
    int bad_gap, bad_hot, bad_dir;
    int lat = 1;
    bit exp_up;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // counter model: applies each step to its counter and acknowledges it after lat cycles
    initial begin
        for (int i = 0; i < NC; i++) pos[i] = 0;
        forever begin
            @(negedge clk);
            if (|step_strobe) begin
                if (!$onehot(step_strobe)) bad_hot++;
                for (int i = 0; i < NC; i++)
                    if (step_strobe[i]) pos[i] = step_up ? (pos[i] + 1) % 8 : (pos[i] + 7) % 8;
                if (n_strobe == 0) first_cyc = cyc;
                else if (cyc - last_ack_cyc != MIN_GAP + 1) begin
                    bad_gap++;
                    gap_seen = cyc - last_ack_cyc;
                end
                if (step_up !== exp_up) bad_dir++;
                n_strobe++;
                repeat (lat) @(negedge clk);
                model_ack = 1'b1;
                last_ack_cyc = cyc;
                @(negedge clk);
                model_ack = 1'b0;
            end
        end
    end

    task automatic clear_stats(input bit up, input int l);
        n_strobe = 0; bad_gap = 0; bad_hot = 0; bad_dir = 0;
        gap_seen = MIN_GAP + 1; exp_up = up; lat = l;
    endtask

    task automatic wait_done(output int wd);
        wd = 0;
        while (!done && wd < 300) begin
            @(negedge clk);
            wd++;
        end
    endtask

    task automatic check_positions(input int tgt);
        for (int i = 0; i < NC; i++)
            chk(pos[i] == exp_pos[i], (i == tgt) ? "R4 position" : "R2 untouched counter",
                pos[i], exp_pos[i]);
    endtask

    task automatic run_req(input int tgt, input int steps, input bit up, input int l, input bit legal);
        int acc;
        int wd;
        clear_stats(up, l);
        @(negedge clk);
        req_valid = 1'b1; req_target = 4'(tgt); req_steps = 3'(steps); req_up = up;
        while (!req_ready) @(negedge clk);
        acc = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        if (legal) begin
            chk(busy == 1'b1, "R6 busy after accept", int'(busy), 1);
            wait_done(wd);
            chk(done == 1'b1 && cyc == last_ack_cyc + 1, "R8 done timing", cyc - last_ack_cyc, 1);
            chk(busy == 1'b1, "R6 busy in done cycle", int'(busy), 1);
            chk(first_cyc == acc + 1, "R7 first step", first_cyc - acc, 1);
            chk(n_strobe == steps, "R3 step count", n_strobe, steps);
            chk(bad_gap == 0, "R7 step spacing", gap_seen, MIN_GAP + 1);
            chk(bad_hot == 0, "R2 one-hot strobe", bad_hot, 0);
            chk(bad_dir == 0, "R4 direction", bad_dir, 0);
            exp_pos[tgt] = up ? (exp_pos[tgt] + steps) % 8 : (exp_pos[tgt] + 8 - steps) % 8;
            check_positions(tgt);
            @(negedge clk);
            chk(!done && req_ready && !busy, "R8 idle after done", int'(done), 0);
        end else begin
            chk(err == 1'b1, "R9 error pulse", int'(err), 1);
            chk(req_ready && !busy, "R9 stays idle", int'(busy), 0);
            @(negedge clk);
            chk(err == 1'b0, "R9 error one cycle", int'(err), 0);
            repeat (8) @(negedge clk);
            chk(n_strobe == 0, "R9 no step", n_strobe, 0);
            check_positions(tgt);
        end
    endtask

    initial begin : main
        int wd;
        for (int i = 0; i < NC; i++) exp_pos[i] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R1 flags", int'(busy), 0);
        chk(step_strobe == '0, "R1 strobe", int'(step_strobe), 0);

        // sweep all targets, counts and directions
        for (int t = 0; t < NC; t++)
            for (int s = 1; s <= 7; s++)
                for (int d = 0; d < 2; d++)
                    run_req(t, s, d[0], ((t + s + d) % 3) + 1, 1'b1);

        // illegal codes and zero count
        for (int t = NC; t < 16; t++) run_req(t, 3, 1'b1, 1, 1'b0);
        run_req(4, 0, 1'b1, 1, 1'b0);

        // R5: request held during a run is not taken
        clear_stats(1'b1, 2);
        @(negedge clk);
        req_valid = 1'b1; req_target = 4'd2; req_steps = 3'd3; req_up = 1'b1;
        @(negedge clk);
        req_target = 4'd5; req_steps = 3'd7; req_up = 1'b0;
        for (int k = 0; k < 6; k++) begin
            chk(req_ready == 1'b0, "R5 not ready while busy", int'(req_ready), 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        wait_done(wd);
        chk(n_strobe == 3, "R5 only first request stepped", n_strobe, 3);
        exp_pos[2] = (exp_pos[2] + 3) % 8;
        check_positions(2);
        @(negedge clk);

        // R10: stray acknowledge while idle
        spur_ack = 1'b1;
        repeat (3) @(negedge clk);
        spur_ack = 1'b0;
        chk(req_ready && !done && !busy, "R10 idle ack ignored", int'(busy), 0);
        run_req(7, 2, 1'b0, 1, 1'b1);
        chk(n_strobe == 2, "R10 next request full length", n_strobe, 2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule